// File: doc/BRIEF.md
# Condition-Mask Branch Resolver

This block settles where a program goes next after a branch-class instruction. It keeps the program counter in a register. For each instruction it takes a strobe, an operation class, a length flag, a 4-bit test mask, the 4-bit condition code and a precomputed target address. When the strobe is high, it decides whether the branch is taken and loads the counter at the closing clock edge.

There are two conditional classes, and both test the bitwise AND of the mask with the condition code. The true-test class branches when that AND has any bit set. The false-test class branches when the AND is all zero. With a zero mask, the false-test class becomes an unconditional jump and the true-test class becomes a no-operation.

A third class, branch-and-link, always jumps. It also presents the return address (the sequential successor) on a link write port for the register file. The condition code is only read, never produced. Address generation happens upstream and is not part of this block.

Top module: `cond_branch_unit`

## Requirements
- R1: After reset (`rst_n` low), `pc` equals RESET_PC (default 0x0000), and `taken` and `link_we` are 0.
- R2: With `resolve`=1 and `op_class`=2'b00 (true-test), `taken` is 1 in that same cycle exactly when `mask & cc` is non-zero. The condition-code bit weights are C=8, V=4, G=2, L=1.
- R3: With `resolve`=1 and `op_class`=2'b01 (false-test), `taken` is 1 in that same cycle exactly when `mask & cc` is zero.
- R4: On the clock edge that ends a strobe cycle, `pc` loads `target` if the branch is taken. Otherwise it loads `pc`+2 when `long_form`=0, or `pc`+4 when `long_form`=1. `next_pc` shows that value during the strobe cycle.
- R5: With mask 0, the false-test class is always taken and the true-test class is never taken, whatever `cc` holds.
- R6: With `resolve`=1 and `op_class`=2'b10 (link), `taken`=1 and `link_we`=1, `link_data` is `pc`+2 (short) or `pc`+4 (long), and `pc` loads `target`.
- R7: While `resolve`=0, `pc` holds its value, and `taken` and `link_we` are 0.
- R8: `op_class`=2'b11 is ignored. `taken` and `link_we` stay 0 and `pc` holds, even with `resolve`=1.
- R9: All counter arithmetic wraps modulo 2^16. For example, 0xFFFE+2 gives 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| resolve | input | 1 | Single-cycle strobe: resolve this instruction |
| op_class | input | 2 | 00 true-test, 01 false-test, 10 link, 11 ignored |
| long_form | input | 1 | 0: short 2-byte form, 1: long 4-byte form |
| mask | input | 4 | Test mask ANDed with the condition code |
| cc | input | 4 | Condition code: C=8, V=4, G=2, L=1 |
| target | input | 16 | Precomputed branch destination |
| pc | output | 16 | Registered program counter |
| next_pc | output | 16 | Value `pc` takes at the next edge |
| taken | output | 1 | Branch taken, valid in the strobe cycle |
| link_we | output | 1 | Link register write enable |
| link_data | output | 16 | Return address to write |

## Verification
The bench uses the default parameters: a 16-bit counter that resets to zero. With these values a single unconditional jump can place the counter at 0xFFFE or 0xFFFC, so the wrap of both step sizes and of the link address can be reached directly. The 4-bit mask and code are small enough for every mask against every code, under both polarities and both lengths, to be covered exhaustively. A table of the common fixed-mask aliases (zero, plus, minus, carry, overflow, not-low) is run first.

// File: rtl/cond_branch_unit.sv
module cond_branch_unit #(
  parameter int PC_W = 16,
  parameter int CC_W = 4,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            resolve,
  input  logic [1:0]      op_class,
  input  logic            long_form,
  input  logic [CC_W-1:0] mask,
  input  logic [CC_W-1:0] cc,
  input  logic [PC_W-1:0] target,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            link_we,
  output logic [PC_W-1:0] link_data
);
  localparam logic [1:0] OP_TRUE  = 2'b00;
  localparam logic [1:0] OP_FALSE = 2'b01;
  localparam logic [1:0] OP_LINK  = 2'b10;
  localparam logic [PC_W-1:0] STEP_SHORT = PC_W'(2);
  localparam logic [PC_W-1:0] STEP_LONG  = PC_W'(4);

  logic            hit;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc;

  assign hit    = |(mask & cc);
  assign seq_pc = pc_q + (long_form ? STEP_LONG : STEP_SHORT);

  always_comb begin
    taken   = 1'b0;
    link_we = 1'b0;
    if (resolve) begin
      case (op_class)
        OP_TRUE:  taken = hit;
        OP_FALSE: taken = !hit;
        OP_LINK:  begin taken = 1'b1; link_we = 1'b1; end
        default:  taken = 1'b0;
      endcase
    end
  end

  assign link_data = seq_pc;
  assign next_pc   = !resolve || op_class == 2'b11 ? pc_q :
                     taken ? target : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= next_pc;
  end

  assign pc = pc_q;
endmodule

// File: rtl/cond_branch_chk.sv
module cond_branch_chk #(
  parameter int PC_W = 16,
  parameter int CC_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            resolve,
  input logic [1:0]      op_class,
  input logic            long_form,
  input logic [CC_W-1:0] mask,
  input logic [PC_W-1:0] target,
  input logic [PC_W-1:0] pc,
  input logic            taken,
  input logic            link_we
);
  logic [PC_W-1:0] step;
  assign step = long_form ? PC_W'(4) : PC_W'(2);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |=> pc == $past(pc));
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve |-> !taken && !link_we);
  a_r5_uncond: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && op_class == 2'b01 && mask == '0 |-> taken);
  a_r5_nop: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && op_class == 2'b00 && mask == '0 |-> !taken);
  a_r6_link_flags: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && op_class == 2'b10 |-> taken && link_we);
  a_r4_taken_loads: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && taken |=> pc == $past(target));
  a_r4_fall_step: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && !taken && op_class != 2'b11 |=> pc == PC_W'($past(pc) + $past(step)));
  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    resolve && op_class == 2'b11 |-> !taken && !link_we);
endmodule

bind cond_branch_unit cond_branch_chk #(.PC_W(PC_W), .CC_W(CC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .resolve(resolve), .op_class(op_class),
  .long_form(long_form), .mask(mask), .target(target), .pc(pc),
  .taken(taken), .link_we(link_we)
);

// File: tb/tb_cond_branch_unit.sv
module tb_cond_branch_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        resolve = 0;
  logic [1:0]  op_class = 0;
  logic        long_form = 0;
  logic [3:0]  mask = 0;
  logic [3:0]  cc = 0;
  logic [15:0] target = 0;
  logic [15:0] pc, next_pc, link_data;
  logic        taken, link_we;

  int errors = 0;
  int checks = 0;
  logic [15:0] model_pc = 16'h0000;
  logic        done = 0;

  always #2.5 clk = ~clk;

  cond_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .resolve(resolve), .op_class(op_class),
    .long_form(long_form), .mask(mask), .cc(cc), .target(target),
    .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
    .link_data(link_data)
  );

  typedef struct packed {
    logic [1:0] op;
    logic       lng;
    logic [3:0] m;
    logic [3:0] c;
    logic       exp_t;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b01, 1'b1, 4'd3, 4'd0,  1'b1},
    '{2'b01, 1'b1, 4'd3, 4'd2,  1'b0},
    '{2'b00, 1'b0, 4'd3, 4'd1,  1'b1},
    '{2'b00, 1'b1, 4'd2, 4'd2,  1'b1},
    '{2'b00, 1'b1, 4'd2, 4'd1,  1'b0},
    '{2'b00, 1'b0, 4'd1, 4'd1,  1'b1},
    '{2'b01, 1'b0, 4'd1, 4'd1,  1'b0},
    '{2'b00, 1'b1, 4'd8, 4'd8,  1'b1},
    '{2'b00, 1'b1, 4'd8, 4'd7,  1'b0},
    '{2'b00, 1'b0, 4'd4, 4'd4,  1'b1},
    '{2'b01, 1'b1, 4'd8, 4'd8,  1'b0},
    '{2'b01, 1'b0, 4'd8, 4'd0,  1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] op, input logic lng, input logic [3:0] m,
                        input logic [3:0] c, input logic [15:0] tgt, input string req);
    logic        hit, exp_t, exp_we;
    logic [15:0] seq, exp_next;
    hit = |(m & c);
    seq = model_pc + (lng ? 16'd4 : 16'd2);
    exp_t  = (op == 2'b00) ? hit : (op == 2'b01) ? !hit : (op == 2'b10);
    exp_we = (op == 2'b10);
    exp_next = (op == 2'b11) ? model_pc : exp_t ? tgt : seq;
    @(negedge clk);
    resolve = 1; op_class = op; long_form = lng; mask = m; cc = c; target = tgt;
    #1;
    check(taken == exp_t, req, 16'(taken), 16'(exp_t));
    check(link_we == exp_we, req, 16'(link_we), 16'(exp_we));
    if (exp_we) check(link_data == seq, {req, " R6 link"}, link_data, seq);
    @(negedge clk);
    resolve = 0;
    check(pc == exp_next, {req, " R4 pc"}, pc, exp_next);
    model_pc = exp_next;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pc == 16'h0000, "R1 pc", pc, 16'h0000);
    check(taken == 0 && link_we == 0, "R1 flags", {taken, link_we}, 16'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].op, VECS[i].lng, VECS[i].m, VECS[i].c, 16'h1000 + 16'(i * 16),
             VECS[i].exp_t ? "R2/R3 alias" : "R2/R3 alias fall");

    // R2 R3 R5 exhaustive: every mask x cc x polarity x length
    for (int op = 0; op < 2; op++)
      for (int lng = 0; lng < 2; lng++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 16; c++)
            run_op(2'(op), 1'(lng), 4'(m), 4'(c), 16'(16'h2000 + m * 256 + c * 4),
                   op == 0 ? "R2 true-test" : "R3 false-test");

    // R5 mask zero under all-ones code
    run_op(2'b01, 0, 4'd0, 4'hF, 16'h0ABC, "R5 uncond");
    run_op(2'b00, 0, 4'd0, 4'hF, 16'h0DEF, "R5 nop");

    // R6 link short and long
    run_op(2'b10, 0, 4'd0, 4'd0, 16'h3000, "R6 link short");
    run_op(2'b10, 1, 4'hF, 4'hF, 16'h4000, "R6 link long");

    // R8 reserved class ignored
    run_op(2'b11, 1, 4'hF, 4'hF, 16'h5555, "R8 reserved");

    // R7 no strobe: inputs present but pc holds
    @(negedge clk);
    resolve = 0; op_class = 2'b10; mask = 0; cc = 0; target = 16'h7777;
    #1;
    check(taken == 0 && link_we == 0, "R7 idle flags", {taken, link_we}, 16'd0);
    @(negedge clk);
    check(pc == model_pc, "R7 idle pc", pc, model_pc);

    // R9 wrap
    run_op(2'b01, 0, 4'd0, 4'd0, 16'hFFFE, "R9 setup");
    run_op(2'b00, 0, 4'd0, 4'd0, 16'h1111, "R9 wrap short");
    check(pc == 16'h0000, "R9 wrap short value", pc, 16'h0000);
    run_op(2'b01, 0, 4'd0, 4'd0, 16'hFFFC, "R9 setup long");
    run_op(2'b10, 1, 4'd0, 4'd0, 16'h0100, "R9 link wrap");
    run_op(2'b01, 0, 4'd0, 4'd0, 16'hFFFE, "R9 setup");
    run_op(2'b00, 1, 4'd0, 4'd0, 16'h2222, "R9 wrap long");
    check(pc == 16'h0002, "R9 wrap long value", pc, 16'h0002);

    // R1 reset again mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(pc == 16'h0000, "R1 re-reset", pc, 16'h0000);
    rst_n = 1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule